// File: doc/BRIEF.md
# DPLL Holdover Frequency-Word Controller

This block sits between the loop filter of a digital PLL and its digitally controlled oscillator. On every update tick it takes a signed frequency-error word and multiplies it by a selectable gain. The result is saturated to the signed word range. While the loop is tracking, the scaled word goes towards the oscillator. The block also records it in three places: the most recent word, a circular history of the last `HIST_DEPTH` words and a first-order running average.

When the loop loses its reference, the holdover request is raised. The block then freezes all its history and holds a frequency word chosen by configuration. Without averaging enabled, it holds the last tracked word. With averaging enabled, it holds one of three things: the word from a fixed number of ticks before holdover began, the running average, or mid-scale.

Every output change passes through a slope limiter. The limiter clamps the step per tick to one of two programmable rates, or lets the step through unlimited.

Top module: `dpll_hold_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `ctrl_o` and `valid_o` become 0, and the last-word, average and every history entry are cleared to 0.
- R2: `valid_o` is high for exactly the cycle after each cycle in which `tick_i` is sampled high. `ctrl_o` changes only at an edge where `tick_i` is high.
- R3: The scaled word is the error multiplied by the gain from `gain_i`: 00 halves the error (arithmetic shift right, rounding towards minus infinity), 01 passes it unchanged, 10 doubles it and 11 quadruples it. Results beyond the signed W-bit range saturate to +2^(W-1)-1 or -2^(W-1).
- R4: On a tick with `hold_i` low, the target word is the scaled word of that tick. That scaled word then becomes the last word, is written into the history and updates the average.
- R5: On a tick with `hold_i` high and `avg_en_i` low, the target is the last word scaled on a non-holdover tick.
- R6: On a tick with `hold_i` high, `avg_en_i` high and `hmode_i` equal to 00 or 10, the target is the oldest of the last `HIST_DEPTH` non-holdover scaled words. This is the word from `HIST_DEPTH` ticks before holdover entry. History slots that were never written read as 0.
- R7: On a tick with `hold_i` high, `avg_en_i` high and `hmode_i` 01, the target is the running average. On every non-holdover tick the average updates as avg += (x - avg) >>> `AVG_SHIFT`, arithmetic, on the scaled word x.
- R8: On a tick with `hold_i` high, `avg_en_i` high and `hmode_i` 11, the target is mid-scale, which for this signed word is 0.
- R9: `slope_i` 01 limits each output step to ±`SLOPE_FAST`, and 10 limits it to ±`SLOPE_SLOW`. Codes 00 and 11 apply no limit, so the output equals the target.
- R10: Holdover ticks leave the last word, the average and the history unchanged. Tracking resumes from that frozen state when `hold_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Update strobe, one cycle per loop update |
| hold_i | input | 1 | Holdover request (reference lost) |
| err_i | input | W | Signed frequency-error word from the loop filter |
| gain_i | input | 2 | Gain code: 00 ×0.5, 01 ×1, 10 ×2, 11 ×4 |
| hmode_i | input | 2 | Holdover source: 00/10 delayed word, 01 average, 11 mid-scale |
| avg_en_i | input | 1 | Enables the holdover source chosen by `hmode_i` |
| slope_i | input | 2 | Slope limit: 00/11 none, 01 fast, 10 slow |
| ctrl_o | output | W | Signed oscillator control word |
| valid_o | output | 1 | High the cycle after each update |

## Verification
The bench first drives single ticks with a direct view of the output: small values at unit gain and odd negative values at half gain, which separate floor rounding from truncation. Large values at gains 2 and 4 separate saturation from wrap-around. A ramp of distinct words then fills the history. The holdover sources are each selected in turn on that ramp, so the last word, the delayed word, the average and mid-scale all give different values, and a wrong depth or wrong pointer shows up as the wrong ramp step. A holdover interval with a changing error, followed by a single tracking tick and a fresh holdover, shows whether the history stayed frozen. Large target jumps under each slope code show the step size, and a long random mix compares every cycle with a behavioural model.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

    typedef enum logic [1:0] {
        GAIN_HALF = 2'b00,
        GAIN_ONE  = 2'b01,
        GAIN_TWO  = 2'b10,
        GAIN_FOUR = 2'b11
    } gain_e;

    typedef enum logic [1:0] {
        HSRC_DELAY = 2'b00,
        HSRC_AVG   = 2'b01,
        HSRC_RSVD  = 2'b10,
        HSRC_MID   = 2'b11
    } hold_src_e;

    typedef enum logic [1:0] {
        SLOPE_OFF  = 2'b00,
        SLOPE_FST  = 2'b01,
        SLOPE_SLW  = 2'b10,
        SLOPE_RSVD = 2'b11
    } slope_e;

    typedef struct packed {
        logic      avg_en;
        hold_src_e src;
    } hold_cfg_t;

endpackage

// File: rtl/dhc_scaler.sv
module dhc_scaler
    import dhc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic signed [W-1:0] err_i,
    input  gain_e               gain_i,
    output logic signed [W-1:0] scaled_o
);
    localparam int XW = W + 3;
    localparam logic signed [XW-1:0] MAXV = {{(XW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] MINV = {{(XW-W+1){1'b1}}, {(W-1){1'b0}}};

    logic signed [XW-1:0] ext;
    logic signed [XW-1:0] prod;

    always_comb begin
        ext = {{3{err_i[W-1]}}, err_i};
        unique case (gain_i)
            GAIN_HALF: prod = ext >>> 1;
            GAIN_ONE:  prod = ext;
            GAIN_TWO:  prod = ext <<< 1;
            default:   prod = ext <<< 2;
        endcase
        if (prod > MAXV)      scaled_o = MAXV[W-1:0];
        else if (prod < MINV) scaled_o = MINV[W-1:0];
        else                  scaled_o = prod[W-1:0];
    end
endmodule

// File: rtl/dhc_history.sv
module dhc_history
    import dhc_pkg::*;
#(
    parameter int W          = 16,
    parameter int HIST_DEPTH = 8,
    parameter int AVG_SHIFT  = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_i,
    input  logic signed [W-1:0] word_i,
    input  hold_cfg_t           cfg_i,
    output logic signed [W-1:0] hold_word_o
);
    localparam int AW = (HIST_DEPTH > 1) ? $clog2(HIST_DEPTH) : 1;
    localparam logic [AW-1:0] LAST_SLOT = AW'(HIST_DEPTH - 1);

    logic signed [W-1:0] hist_q [HIST_DEPTH];
    logic [AW-1:0]       ptr_q;
    logic signed [W-1:0] last_q;
    logic signed [W-1:0] avg_q;
    logic signed [W:0]   avg_diff;
    logic signed [W:0]   avg_step;
    logic signed [W:0]   avg_sum;

    always_comb begin
        avg_diff = {word_i[W-1], word_i} - {avg_q[W-1], avg_q};
        avg_step = avg_diff >>> AVG_SHIFT;
        avg_sum  = {avg_q[W-1], avg_q} + avg_step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            last_q <= '0;
            avg_q  <= '0;
        end else if (wr_i) begin
            ptr_q  <= (ptr_q == LAST_SLOT) ? '0 : ptr_q + 1'b1;
            last_q <= word_i;
            avg_q  <= avg_sum[W-1:0];
        end
    end

    for (genvar gi = 0; gi < HIST_DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                hist_q[gi] <= '0;
            else if (wr_i && ptr_q == AW'(gi))
                hist_q[gi] <= word_i;
        end
    end

    always_comb begin
        if (!cfg_i.avg_en) begin
            hold_word_o = last_q;
        end else begin
            unique case (cfg_i.src)
                HSRC_AVG: hold_word_o = avg_q;
                HSRC_MID: hold_word_o = '0;
                default:  hold_word_o = hist_q[ptr_q];
            endcase
        end
    end
endmodule

// File: rtl/dhc_slew.sv
module dhc_slew
    import dhc_pkg::*;
#(
    parameter int W          = 16,
    parameter int SLOPE_FAST = 64,
    parameter int SLOPE_SLOW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick_i,
    input  logic signed [W-1:0] target_i,
    input  slope_e              slope_i,
    output logic signed [W-1:0] ctrl_o,
    output logic                valid_o
);
    localparam logic signed [W:0] FAST_L = (W+1)'(SLOPE_FAST);
    localparam logic signed [W:0] SLOW_L = (W+1)'(SLOPE_SLOW);

    logic signed [W:0] diff;
    logic signed [W:0] lim;
    logic              limited;
    logic signed [W:0] next_w;

    always_comb begin
        diff    = {target_i[W-1], target_i} - {ctrl_o[W-1], ctrl_o};
        limited = 1'b1;
        lim     = FAST_L;
        unique case (slope_i)
            SLOPE_FST: lim = FAST_L;
            SLOPE_SLW: lim = SLOW_L;
            default:   limited = 1'b0;
        endcase
        if (limited && diff > lim)
            next_w = {ctrl_o[W-1], ctrl_o} + lim;
        else if (limited && diff < -lim)
            next_w = {ctrl_o[W-1], ctrl_o} - lim;
        else
            next_w = {target_i[W-1], target_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= tick_i;
            if (tick_i) ctrl_o <= next_w[W-1:0];
        end
    end
endmodule

// File: rtl/dpll_hold_ctrl.sv
module dpll_hold_ctrl
    import dhc_pkg::*;
#(
    parameter int W          = 16,
    parameter int HIST_DEPTH = 8,
    parameter int AVG_SHIFT  = 3,
    parameter int SLOPE_FAST = 64,
    parameter int SLOPE_SLOW = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         hold_i,
    input  logic [W-1:0] err_i,
    input  logic [1:0]   gain_i,
    input  logic [1:0]   hmode_i,
    input  logic         avg_en_i,
    input  logic [1:0]   slope_i,
    output logic [W-1:0] ctrl_o,
    output logic         valid_o
);
    logic signed [W-1:0] scaled;
    logic signed [W-1:0] hold_word;
    logic signed [W-1:0] target;
    logic signed [W-1:0] ctrl_s;
    hold_cfg_t           cfg;

    assign cfg.avg_en = avg_en_i;
    assign cfg.src    = hold_src_e'(hmode_i);

    dhc_scaler #(.W(W)) u_scale (
        .err_i    (signed'(err_i)),
        .gain_i   (gain_e'(gain_i)),
        .scaled_o (scaled)
    );

    dhc_history #(.W(W), .HIST_DEPTH(HIST_DEPTH), .AVG_SHIFT(AVG_SHIFT)) u_hist (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (tick_i && !hold_i),
        .word_i      (scaled),
        .cfg_i       (cfg),
        .hold_word_o (hold_word)
    );

    assign target = hold_i ? hold_word : scaled;

    dhc_slew #(.W(W), .SLOPE_FAST(SLOPE_FAST), .SLOPE_SLOW(SLOPE_SLOW)) u_slew (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .target_i (target),
        .slope_i  (slope_e'(slope_i)),
        .ctrl_o   (ctrl_s),
        .valid_o  (valid_o)
    );

    assign ctrl_o = ctrl_s;
endmodule

// File: rtl/dhc_checker.sv
module dhc_checker #(
    parameter int W          = 16,
    parameter int SLOPE_FAST = 64,
    parameter int SLOPE_SLOW = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick_i,
    input logic         hold_i,
    input logic [W-1:0] err_i,
    input logic [1:0]   gain_i,
    input logic [1:0]   hmode_i,
    input logic         avg_en_i,
    input logic [1:0]   slope_i,
    input logic [W-1:0] ctrl_o,
    input logic         valid_o
);
    localparam logic signed [W:0] FAST_L = (W+1)'(SLOPE_FAST);
    localparam logic signed [W:0] SLOW_L = (W+1)'(SLOPE_SLOW);

    logic [W-1:0]      prev_q;
    logic signed [W:0] step;

    always_ff @(posedge clk) prev_q <= ctrl_o;
    assign step = signed'({ctrl_o[W-1], ctrl_o}) - signed'({prev_q[W-1], prev_q});

    assert_valid_follows_tick_R2: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> valid_o);
    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> !valid_o);
    assert_word_held_R2: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(ctrl_o));
    assert_unity_gain_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !hold_i && gain_i == 2'b01 && slope_i == 2'b00) |=> ctrl_o == $past(err_i));
    assert_midscale_R8: assert property (@(posedge clk) disable iff (rst)
        (tick_i && hold_i && avg_en_i && hmode_i == 2'b11 && slope_i == 2'b00) |=> ctrl_o == '0);
    assert_slow_step_R9: assert property (@(posedge clk) disable iff (rst)
        (tick_i && slope_i == 2'b10) |=> (step <= SLOW_L && step >= -SLOW_L));
    assert_fast_step_R9: assert property (@(posedge clk) disable iff (rst)
        (tick_i && slope_i == 2'b01) |=> (step <= FAST_L && step >= -FAST_L));
endmodule

bind dpll_hold_ctrl dhc_checker #(.W(W), .SLOPE_FAST(SLOPE_FAST), .SLOPE_SLOW(SLOPE_SLOW)) chk_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .hold_i(hold_i), .err_i(err_i),
    .gain_i(gain_i), .hmode_i(hmode_i), .avg_en_i(avg_en_i), .slope_i(slope_i),
    .ctrl_o(ctrl_o), .valid_o(valid_o)
);

// File: tb/dpll_hold_ctrl_tb_top.sv
`timescale 1ns/1ps
module dpll_hold_ctrl_tb_top;
    localparam int W = 16, D = 8, K = 3, LF = 64, LS = 8;
    localparam int MAXV = (1 <<< (W-1)) - 1;
    localparam int MINV = -(1 <<< (W-1));

    logic clk = 0, rst = 1, tick = 0, hold = 0, aen = 0;
    logic [W-1:0] err = '0;
    logic [1:0] gain = 2'b01, hmode = 2'b00, slope = 2'b00;
    logic [W-1:0] ctrl;
    logic valid;

    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit done = 0;

    int hq[$];
    int m_last, m_avg, m_out;
    bit m_valid;

    always #4 clk = ~clk;

    dpll_hold_ctrl #(.W(W), .HIST_DEPTH(D), .AVG_SHIFT(K), .SLOPE_FAST(LF), .SLOPE_SLOW(LS)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .hold_i(hold), .err_i(err), .gain_i(gain),
        .hmode_i(hmode), .avg_en_i(aen), .slope_i(slope), .ctrl_o(ctrl), .valid_o(valid));

    function automatic int sat(int v);
        if (v > MAXV) return MAXV;
        if (v < MINV) return MINV;
        return v;
    endfunction

    function automatic int scale(int e, int g);
        case (g)
            0: return sat(e >>> 1);
            1: return sat(e);
            2: return sat(e * 2);
            default: return sat(e * 4);
        endcase
    endfunction

    task automatic model_reset();
        hq = {};
        for (int i = 0; i < D; i++) hq.push_back(0);
        m_last = 0; m_avg = 0; m_out = 0; m_valid = 0;
    endtask

    task automatic model_step();
        int sc, tgt, d, lim;
        if (rst) begin model_reset(); return; end
        m_valid = tick;
        if (!tick) return;
        sc = scale($signed(err), gain);
        if (hold) begin
            if (!aen) tgt = m_last;
            else if (hmode == 2'b01) tgt = m_avg;
            else if (hmode == 2'b11) tgt = 0;
            else tgt = hq[0];
        end else begin
            tgt = sc;
            m_last = sc;
            m_avg = m_avg + ((sc - m_avg) >>> K);
            hq.push_back(sc);
            void'(hq.pop_front());
        end
        d = tgt - m_out;
        lim = (slope == 2'b01) ? LF : (slope == 2'b10) ? LS : 0;
        if (lim != 0 && d > lim) d = lim;
        else if (lim != 0 && d < -lim) d = -lim;
        m_out = m_out + d;
    endtask

    task automatic check_val(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(bit t, int e, bit h);
        tick = t; err = W'(e); hold = h;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        check_val(cur_req, $signed(ctrl), m_out, "ctrl_o vs model");
        check_val(cur_req, int'(valid), int'(m_valid), "valid_o vs model");
        tick = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        rst = 1;
        cyc(1, 500, 0); cyc(1, 700, 0);
        rst = 0;
        // R1: reset state
        check_val("R1", $signed(ctrl), 0, "ctrl_o after reset");
        check_val("R1", int'(valid), 0, "valid_o after reset");

        // R3: gain and saturation
        cur_req = "R3";
        gain = 2'b01; cyc(1, 1000, 0);  check_val("R3", $signed(ctrl), 1000, "x1");
        gain = 2'b00; cyc(1, -3, 0);    check_val("R3", $signed(ctrl), -2, "x0.5 floor");
        gain = 2'b10; cyc(1, 20000, 0); check_val("R3", $signed(ctrl), 32767, "x2 sat");
        gain = 2'b11; cyc(1, -10000, 0); check_val("R3", $signed(ctrl), -32768, "x4 sat");
        gain = 2'b11; cyc(1, 5000, 0);  check_val("R3", $signed(ctrl), 20000, "x4");

        // R2: gaps between ticks, error moving while idle
        cur_req = "R2";
        cyc(0, 123, 0); cyc(0, -77, 1);
        check_val("R2", $signed(ctrl), 20000, "held without tick");
        cyc(1, 10, 0); cyc(0, 0, 0);

        // R4: ramp fills history
        cur_req = "R4";
        model_reset(); rst = 1; cyc(0, 0, 0); rst = 0;
        gain = 2'b01;
        for (int i = 1; i <= 12; i++) cyc(1, 100 * i, 0);
        check_val("R4", $signed(ctrl), 1200, "tracking");

        cur_req = "R5"; aen = 0;
        cyc(1, -5000, 1); check_val("R5", $signed(ctrl), 1200, "last word");
        cur_req = "R6"; aen = 1; hmode = 2'b00;
        cyc(1, 9999, 1); check_val("R6", $signed(ctrl), 500, "delayed word");
        hmode = 2'b10;
        cyc(1, 1, 1); check_val("R6", $signed(ctrl), 500, "reserved code as delay");
        cur_req = "R7"; hmode = 2'b01;
        cyc(1, 7, 1); check_val("R7", $signed(ctrl), m_avg, "average");
        cur_req = "R8"; hmode = 2'b11;
        cyc(1, 3333, 1); check_val("R8", $signed(ctrl), 0, "mid-scale");

        // R10: frozen during hold, resumes after
        cur_req = "R10";
        cyc(1, 1300, 0);
        hmode = 2'b00;
        cyc(1, 0, 1); check_val("R10", $signed(ctrl), 600, "history resumed one step");
        aen = 0;
        cyc(1, 0, 1); check_val("R10", $signed(ctrl), 1300, "last word after resume");

        // R9: slope limits
        cur_req = "R9";
        slope = 2'b10; cyc(1, -2000, 0);
        check_val("R9", $signed(ctrl), 1292, "slow step");
        slope = 2'b01; cyc(1, -2000, 0);
        check_val("R9", $signed(ctrl), 1228, "fast step");
        slope = 2'b11; cyc(1, -2000, 0);
        check_val("R9", $signed(ctrl), -2000, "reserved no limit");
        slope = 2'b10; cyc(1, -1995, 0);
        check_val("R9", $signed(ctrl), -1995, "small step passes");

        // mixed random traffic against the model
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            gain = 2'($urandom); hmode = 2'($urandom); slope = 2'($urandom);
            aen = 1'($urandom);
            cyc(1'(($urandom % 4) != 0), int'($signed(16'($urandom))), (($urandom % 5) == 0));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule